// File: doc/BRIEF.md
# Strobed Dual-Bank Block Access Front End

This block decodes the random block-access cycles of a memory split into two banks, L and U. An external master drives an active-low row strobe and an active-low column strobe over a shared 10-bit address bus. The block samples both strobes on a system clock, which they are assumed to be synchronous to. It captures the row on the row strobe's falling edge and the column on the column strobe's falling edge. It then issues a write or a read toward a bank array attached at its memory-side port. A 12-bit data word moves in each direction.

The two directions choose the bank differently. On a write, the two lane write enables pick the bank. On a read, the top row address bit picks it. When the column strobe falls before the row strobe, the cycle is a refresh instead of an access. The row to refresh comes from an internal counter, and the address pins play no part. Accesses open only while the ready input from the sequential-mode engine is high. A busy output keeps that engine off the array while a block access is in progress.

Top module: `dbank_blk_front`

## Requirements
- R1: On an accepted row-strobe fall, `mem_row` takes `adr`. On the first qualifying column-strobe fall, `mem_col` takes `adr`.
- R2: At the row-strobe fall, the cycle is a write if `wen_lo_n` or `wen_hi_n` is low. It is a read if both are high. A read never pulses `mem_we`.
- R3: On a write, `wen_lo_n` low with `wen_hi_n` high selects bank 0 (L), and `wen_hi_n` low with `wen_lo_n` high selects bank 1 (U). If both are low, `wr_conflict` is raised for the cycle and bank 0 is used.
- R4: A column-strobe fall counts only if it is detected at least CASB_CYC clock edges after the edge that detected the row-strobe fall. That fall captures `data_in` as the write word. Earlier column falls are ignored.
- R5: The write is committed on the edge that detects the row strobe rising. `mem_we` pulses for one cycle with the captured bank, row, column and word. If no qualifying column fall occurred, there is no pulse.
- R6: On a read, the top row address bit selects the bank: 0 selects L and 1 selects U.
- R7: If `rd_en_n` is low at a qualifying column fall of a read, `data_oe` rises and `data_out` holds `mem_rdata` two edges after that fall. If `rd_en_n` is high, `data_oe` stays low.
- R8: `data_oe` drops on the edge that detects the row strobe rising.
- R9: A row-strobe fall with the column strobe high while `seq_ready` is low is ignored. No access starts, and the sticky `acc_err` is set. Only reset clears it.
- R10: A row-strobe fall while the column strobe is already low is a refresh. `ref_pulse` pulses with `ref_row` equal to the counter value, and no access starts.
- R11: The refresh counter resets to 0, steps by one per refresh, and wraps from 1023 to 0.
- R12: `blk_busy` is high from the edge that accepts an access until the edge that detects its row-strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wen_lo_n | input | 1 | Lower-lane write enable, active low |
| wen_hi_n | input | 1 | Upper-lane write enable, active low |
| rd_en_n | input | 1 | Read output enable, active low |
| adr | input | 10 | Shared row/column address |
| data_in | input | 12 | Write data from the pins |
| seq_ready | input | 1 | High once sequential-mode self refresh is done |
| mem_rdata | input | 12 | Word returned by the bank array |
| data_out | output | 12 | Read data toward the pins |
| data_oe | output | 1 | Output enable for data_out |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_bank | output | 1 | Bank select, 0 = L, 1 = U |
| mem_row | output | 10 | Latched row address |
| mem_col | output | 10 | Latched column address |
| mem_wdata | output | 12 | Captured write word |
| ref_pulse | output | 1 | One-cycle refresh strobe |
| ref_row | output | 10 | Row being refreshed |
| wr_conflict | output | 1 | Both lane enables were low on this write |
| blk_busy | output | 1 | Block access in progress |
| acc_err | output | 1 | Sticky flag for an access refused while not ready |

## Verification
The bench uses the default parameters: a 10-bit address, a 12-bit word and CASB_CYC of 2. With a 2-edge gap, a column strobe sent one cycle early lands just inside the ignore window, and one sent on time lands exactly on its boundary. With a 10-bit counter, 1024 strobe-ordered refreshes of three cycles each carry the counter through its wrap well within the run. Because the address is 10 bits, a row with the top bit set can also be written to bank L and then read from bank U, which shows that the two directions choose the bank differently.

// File: rtl/dbank_pkg.sv
package dbank_pkg;
  typedef enum logic {BANK_L = 1'b0, BANK_U = 1'b1} bank_e;

  function automatic logic is_write_req(input logic lo_n, input logic hi_n);
    return !(lo_n && hi_n);
  endfunction

  function automatic logic lanes_clash(input logic lo_n, input logic hi_n);
    return !lo_n && !hi_n;
  endfunction

  // upper lane alone picks U; lower alone or both pick L
  function automatic bank_e write_bank(input logic lo_n, input logic hi_n);
    return (!hi_n && lo_n) ? BANK_U : BANK_L;
  endfunction

  function automatic logic gap_met(input int unsigned elapsed, input int unsigned need);
    return elapsed >= need;
  endfunction
endpackage

// File: rtl/dbank_strobe_edges.sv
module dbank_strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic row_stb_n,
  input  logic col_stb_n,
  output logic row_fall,
  output logic row_rise,
  output logic col_fall
);
  logic row_q, col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= 1'b1;
      col_q <= 1'b1;
    end else begin
      row_q <= row_stb_n;
      col_q <= col_stb_n;
    end
  end

  assign row_fall = row_q && !row_stb_n;
  assign row_rise = !row_q && row_stb_n;
  assign col_fall = col_q && !col_stb_n;
endmodule

// File: rtl/dbank_refresh_ctr.sv
module dbank_refresh_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_go,
  output logic              ref_pulse,
  output logic [ADDR_W-1:0] ref_row
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ref_row   <= '0;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= ref_go;
      if (ref_go) begin
        ref_row <= cnt_q;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assert_ref_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_go && cnt_q == '1) |=> (cnt_q == '0));
  assert_ref_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_go |=> $stable(cnt_q));
endmodule

// File: rtl/dbank_access_seq.sv
module dbank_access_seq
  import dbank_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 12,
  parameter int CASB_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_fall,
  input  logic              row_rise,
  input  logic              col_fall,
  input  logic              col_stb_n,
  input  logic              wen_lo_n,
  input  logic              wen_hi_n,
  input  logic              rd_en_n,
  input  logic              seq_ready,
  input  logic [ADDR_W-1:0] adr,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              mem_we,
  output bank_e             bank_q,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              clash_q,
  output logic              active_q,
  output logic              err_q
);
  localparam int GAP_W = $clog2(CASB_CYC + 1);

  logic [GAP_W-1:0] gap_q;
  logic wr_q, have_data_q, rd_pend_q;
  logic accept, reject, col_ok;

  assign accept = row_fall && col_stb_n && seq_ready && !active_q;
  assign reject = row_fall && col_stb_n && !seq_ready;
  assign col_ok = active_q && col_fall && gap_met(int'(gap_q), CASB_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0; wr_q <= 1'b0; have_data_q <= 1'b0; rd_pend_q <= 1'b0;
      bank_q <= BANK_L; row_q <= '0; col_q <= '0; wdata_q <= '0;
      clash_q <= 1'b0; active_q <= 1'b0; err_q <= 1'b0;
      data_out <= '0; data_oe <= 1'b0; mem_we <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      rd_pend_q <= 1'b0;
      if (accept) begin
        active_q    <= 1'b1;
        wr_q        <= is_write_req(wen_lo_n, wen_hi_n);
        bank_q      <= is_write_req(wen_lo_n, wen_hi_n) ? write_bank(wen_lo_n, wen_hi_n)
                                                        : bank_e'(adr[ADDR_W-1]);
        clash_q     <= lanes_clash(wen_lo_n, wen_hi_n);
        row_q       <= adr;
        gap_q       <= GAP_W'(1);
        have_data_q <= 1'b0;
      end else if (active_q && gap_q < GAP_W'(CASB_CYC)) begin
        gap_q <= gap_q + 1'b1;
      end
      if (reject) err_q <= 1'b1;
      if (col_ok) begin
        col_q <= adr;
        if (wr_q) begin
          wdata_q     <= data_in;
          have_data_q <= 1'b1;
        end else if (!rd_en_n) begin
          rd_pend_q <= 1'b1;
        end
      end
      if (rd_pend_q && active_q) begin
        data_out <= mem_rdata;
        data_oe  <= 1'b1;
      end
      if (row_rise && active_q) begin
        active_q  <= 1'b0;
        data_oe   <= 1'b0;
        rd_pend_q <= 1'b0;
        mem_we    <= wr_q && have_data_q;
      end
    end
  end

  assert_commit_at_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(active_q) && !active_q));
  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rise && active_q) |=> !data_oe);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_refused_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !active_q) |=> !active_q);
  assert_clash_to_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clash_q |-> (bank_q == BANK_L && wr_q));
  assert_oe_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!wr_q && active_q));
endmodule

// File: rtl/dbank_blk_front.sv
module dbank_blk_front #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 12,
  parameter int CASB_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n,
  input  logic              col_stb_n,
  input  logic              wen_lo_n,
  input  logic              wen_hi_n,
  input  logic              rd_en_n,
  input  logic [ADDR_W-1:0] adr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              seq_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_row,
  output logic [ADDR_W-1:0] mem_col,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ref_pulse,
  output logic [ADDR_W-1:0] ref_row,
  output logic              wr_conflict,
  output logic              blk_busy,
  output logic              acc_err
);
  import dbank_pkg::*;

  logic  row_fall, row_rise, col_fall, ref_go;
  bank_e bank_sel;

  dbank_strobe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .row_fall(row_fall), .row_rise(row_rise), .col_fall(col_fall)
  );

  // column already low when the row strobe falls: strobe-ordered refresh
  assign ref_go = row_fall && !col_stb_n;

  dbank_refresh_ctr #(.ADDR_W(ADDR_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_go(ref_go),
    .ref_pulse(ref_pulse), .ref_row(ref_row)
  );

  dbank_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CASB_CYC(CASB_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .row_fall(row_fall), .row_rise(row_rise),
    .col_fall(col_fall), .col_stb_n(col_stb_n), .wen_lo_n(wen_lo_n),
    .wen_hi_n(wen_hi_n), .rd_en_n(rd_en_n), .seq_ready(seq_ready), .adr(adr),
    .data_in(data_in), .mem_rdata(mem_rdata), .data_out(data_out),
    .data_oe(data_oe), .mem_we(mem_we), .bank_q(bank_sel), .row_q(mem_row),
    .col_q(mem_col), .wdata_q(mem_wdata), .clash_q(wr_conflict),
    .active_q(blk_busy), .err_q(acc_err)
  );

  assign mem_bank = bank_sel;

  assert_refresh_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_go && !blk_busy) |=> !blk_busy);
  assert_refresh_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> !mem_we);
endmodule

// File: tb/dbank_blk_front_test.sv
`timescale 1ns/1ps
module dbank_blk_front_test;
  localparam int AW = 10;
  localparam int DW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_stb_n = 1'b1, col_stb_n = 1'b1, wen_lo_n = 1'b1, wen_hi_n = 1'b1;
  logic rd_en_n = 1'b1, seq_ready = 1'b1;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] mem_rdata, data_out, mem_wdata;
  logic data_oe, mem_we, mem_bank, ref_pulse, wr_conflict, blk_busy, acc_err;
  logic [AW-1:0] mem_row, mem_col, ref_row;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dbank_blk_front uut (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wen_lo_n(wen_lo_n), .wen_hi_n(wen_hi_n), .rd_en_n(rd_en_n), .adr(adr),
    .data_in(data_in), .seq_ready(seq_ready), .mem_rdata(mem_rdata),
    .data_out(data_out), .data_oe(data_oe), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
    .ref_pulse(ref_pulse), .ref_row(ref_row), .wr_conflict(wr_conflict),
    .blk_busy(blk_busy), .acc_err(acc_err)
  );

  // behavioural two-bank array
  logic [DW-1:0] store [int unsigned];
  function automatic logic [DW-1:0] lookup(input int unsigned key);
    return store.exists(key) ? store[key] : '0;
  endfunction
  assign mem_rdata = lookup({mem_bank, mem_row, mem_col});
  always @(posedge clk) if (mem_we) store[{mem_bank, mem_row, mem_col}] = mem_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // kind: 0 lower-lane write, 1 upper-lane write, 2 read, 3 both-lane write
  logic obs_busy, obs_clash, obs_oe, obs_we, obs_bank, obs_oe_end, obs_busy_end, obs_we_next;
  logic [AW-1:0] obs_row_start, obs_row, obs_col;
  logic [DW-1:0] obs_dout, obs_wd;

  task automatic run_access(input int kind, input logic re_n, input logic [AW-1:0] row,
                            input logic [AW-1:0] col, input logic [DW-1:0] data, input int gap);
    @(negedge clk);
    adr = row;
    wen_lo_n = !(kind == 0 || kind == 3);
    wen_hi_n = !(kind == 1 || kind == 3);
    row_stb_n = 1'b0;
    @(negedge clk);
    obs_busy = blk_busy; obs_row_start = mem_row; obs_clash = wr_conflict;
    wen_lo_n = 1'b1; wen_hi_n = 1'b1;
    repeat (gap - 1) @(negedge clk);
    adr = col; data_in = data; rd_en_n = re_n; col_stb_n = 1'b0;
    repeat (2) @(negedge clk);
    obs_oe = data_oe; obs_dout = data_out;
    row_stb_n = 1'b1; col_stb_n = 1'b1; rd_en_n = 1'b1;
    @(negedge clk);
    obs_we = mem_we; obs_bank = mem_bank; obs_row = mem_row; obs_col = mem_col;
    obs_wd = mem_wdata; obs_oe_end = data_oe; obs_busy_end = blk_busy;
    @(negedge clk);
    obs_we_next = mem_we;
  endtask

  int exp_ref = 0;
  task automatic run_refresh(input logic [AW-1:0] junk);
    @(negedge clk);
    col_stb_n = 1'b0;
    @(negedge clk);
    adr = junk; row_stb_n = 1'b0;
    @(negedge clk);
    check("R10 pulse", ref_pulse, 1);
    check("R11 row", ref_row, exp_ref[AW-1:0]);
    check("R10 no access", {blk_busy, mem_we}, 0);
    exp_ref = (exp_ref + 1) % (1 << AW);
    row_stb_n = 1'b1; col_stb_n = 1'b1;
  endtask

  localparam logic [34:0] VEC [8] = '{
    {2'd0, 1'b0, 10'h005, 10'h011, 12'hA5A},
    {2'd1, 1'b1, 10'h205, 10'h011, 12'h3C3},
    {2'd0, 1'b0, 10'h3FF, 10'h3FF, 12'hFFF},
    {2'd1, 1'b1, 10'h200, 10'h000, 12'h001},
    {2'd2, 1'b0, 10'h005, 10'h011, 12'hA5A},
    {2'd2, 1'b1, 10'h205, 10'h011, 12'h3C3},
    {2'd2, 1'b1, 10'h3FF, 10'h3FF, 12'h000},
    {2'd2, 1'b1, 10'h200, 10'h000, 12'h001}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset busy", blk_busy, 0);
    check("R8 reset oe", data_oe, 0);
    check("R5 reset we", mem_we, 0);
    check("R9 reset err", acc_err, 0);
    check("R10 reset pulse", ref_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [34:0] v = VEC[i];
      int kind = int'(v[34:33]);
      run_access(kind, 1'b0, v[31:22], v[21:12], v[11:0], 2);
      check("R12 busy", obs_busy, 1);
      check("R12 idle after", obs_busy_end, 0);
      check("R1 row", obs_row_start, v[31:22]);
      check("R1 col", obs_col, v[21:12]);
      if (kind < 2) begin
        check("R5 commit", obs_we, 1);
        check("R5 single", obs_we_next, 0);
        check("R3 bank", obs_bank, v[32]);
        check("R4 word", obs_wd, v[11:0]);
      end else begin
        check("R2 read no write", obs_we, 0);
        check("R6 bank", obs_bank, v[32]);
        check("R7 oe", obs_oe, 1);
        check("R7 data", obs_dout, v[11:0]);
        check("R8 release", obs_oe_end, 0);
      end
    end

    // R3 both lanes low
    run_access(3, 1'b0, 10'h201, 10'h002, 12'h777, 2);
    check("R3 clash flag", obs_clash, 1);
    check("R3 clash bank", obs_bank, 0);
    check("R2 write", obs_we, 1);
    run_access(0, 1'b0, 10'h001, 10'h002, 12'h111, 2);
    check("R3 clash clears", obs_clash, 0);

    // R4 column one cycle early: ignored, nothing committed
    run_access(0, 1'b0, 10'h0AA, 10'h0BB, 12'h999, 1);
    check("R4 early col ignored", obs_we, 0);
    check("R4 early col busy", obs_busy, 1);
    run_access(2, 1'b0, 10'h0AA, 10'h0BB, 12'h0, 1);
    check("R4 early read no oe", obs_oe, 0);

    // R7 read with output enable high
    run_access(2, 1'b1, 10'h005, 10'h011, 12'h0, 2);
    check("R7 no drive", obs_oe, 0);

    // R9 refused while not ready
    seq_ready = 1'b0;
    run_access(0, 1'b0, 10'h005, 10'h011, 12'hBAD, 2);
    check("R9 no busy", obs_busy, 0);
    check("R9 no commit", obs_we, 0);
    check("R9 err set", acc_err, 1);
    seq_ready = 1'b1;
    run_access(2, 1'b0, 10'h005, 10'h011, 12'h0, 2);
    check("R9 array untouched", obs_dout, 12'hA5A);
    check("R9 err sticky", acc_err, 1);

    // R10/R11 refresh through the wrap
    for (int n = 0; n < (1 << AW) + 3; n++) run_refresh(AW'(n * 37));
    check("R11 wrapped", exp_ref, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule